// File: doc/BRIEF.md
# Branch-Aware Sequential Prefetch Controller

This block sits in an instruction fetch path between a processor and a slower backing memory. It keeps a small direct-mapped store of instruction lines. A fetch that finds its line resident is answered without touching the backing memory. A fetch that misses loads the whole line from the backing memory. Once the processor has its word, the controller fetches further lines in the background, during cycles when no demand request is waiting.

Three kinds of background fetch exist. After every demand miss, the controller queues the next sequential line, but it does not cross a page boundary. While a demand line streams in, a small opcode detector looks at each word. An unconditional jump queues its target line. A conditional branch queues both its target line and the sequential line, and marks each as speculative, with a branch ID and a path bit. When the processor later resolves that branch, the line for the losing path is invalidated and the winning line stays as an ordinary line.

Both edges use valid/ready. A processor request is accepted only when `cpu_req_ready` is high, and only one request can be outstanding. The response is held stable until `cpu_rsp_ready` is seen. A backing-memory request holds its valid and address until `mem_req_ready`. The memory then returns one word per `mem_rsp_valid` cycle, in ascending order, with no back-pressure on that return path.

Top module: `bpf_ctrl`

## Requirements
- R1: A fetch whose line is resident produces its response in the cycle after acceptance, with `cpu_rsp_hit`=1 and the stored word, and issues no backing-memory request.
- R2: A fetch whose line is absent issues one backing-memory request at the line-aligned word address (low log2(WPL) bits zero). After the WPL returned words, it responds with the requested word and `cpu_rsp_hit`=0.
- R3: After a demand miss on line L, line L+1 is queued. It is fetched from backing memory during idle cycles, so a later fetch inside L+1 hits.
- R4: The sequential line is not queued when L is the last line of a PAGE_BYTES page (4 bytes per word, default 4096), unless the demand line held a conditional branch.
- R5: A demand-fetched word with bits [31:24] = 0x01 is an unconditional jump to the absolute word address in bits [23:0]. The line holding that target is prefetched and then hits.
- R6: A demand-fetched word with bits [31:24] = 0x02 is a conditional branch with the same target format. Both its target line (taken path, path=1) and the sequential line (path=0) are prefetched. Both are tagged speculative with branch ID = the low ID_W bits of the branch's word address.
- R7: On `br_valid` with ID X and outcome T, the resident and queued speculative lines of branch X whose path differs from T are invalidated or discarded from the next cycle. Lines of branch X on path T stay valid.
- R8: A demand request waiting in an idle cycle takes the backing-memory port ahead of any queued prefetch.
- R9: The prefetch queue holds QDEPTH (default 4) entries, and a request arriving when it is full is dropped.
- R10: Handshake rules hold. A processor response stays stable until taken, a memory request holds its address until accepted, and after a request is accepted `cpu_req_ready` is low until the response completes.
- R11: Out of reset, `cpu_req_ready`=1, `cpu_rsp_valid`=0 and `mem_req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Fetch request valid |
| cpu_req_ready | output | 1 | Controller can accept a fetch |
| cpu_req_addr | input | AW | Fetch word address |
| cpu_rsp_valid | output | 1 | Fetch response valid |
| cpu_rsp_ready | input | 1 | Processor takes the response |
| cpu_rsp_data | output | 32 | Fetched instruction word |
| cpu_rsp_hit | output | 1 | 1 = served from the line store |
| mem_req_valid | output | 1 | Line fetch request valid |
| mem_req_ready | input | 1 | Backing memory accepts the request |
| mem_req_addr | output | AW | Line-aligned word address |
| mem_rsp_valid | input | 1 | One returned word valid |
| mem_rsp_data | input | 32 | Returned word |
| br_valid | input | 1 | Conditional branch outcome valid |
| br_id | input | ID_W | Branch ID being resolved |
| br_taken | input | 1 | 1 = branch taken |

## Verification
Some properties are checked on every cycle. These are the handshake holding rules, the single-outstanding-request rule, the one-cycle response to a fetch that looks up as resident, and the immediate memory request after a lookup that misses. Other behaviours need constructed memory contents and timing, so only the bench scenarios can show them. These are the contents of the prefetch stream (next line, jump target, both branch paths), the page-boundary cut-off, the survival or loss of each path after a resolve, demand priority over a non-empty queue, and the drop when the queue is full.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [7:0] OP_JUMP = 8'h01;
  localparam logic [7:0] OP_COND = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DFILL,
    ST_RESP,
    ST_PREQ,
    ST_PFILL
  } ctrl_state_e;
endpackage

// File: rtl/bpf_scan.sv
// Opcode detector for one streamed instruction word.
module bpf_scan
  import bpf_pkg::*;
#(
  parameter int unsigned AW    = 24,
  parameter int unsigned OFF_W = 2,
  parameter int unsigned ID_W  = 4
) (
  input  logic [WORD_W-1:0]   word,
  input  logic [AW-1:0]       waddr,
  output logic                is_jump,
  output logic                is_cond,
  output logic [AW-OFF_W-1:0] tgt_line,
  output logic [ID_W-1:0]     bid
);
  logic [AW-1:0] tgt_word;

  assign is_jump  = (word[31:24] == OP_JUMP);
  assign is_cond  = (word[31:24] == OP_COND);
  assign tgt_word = AW'(word[23:0]);
  assign tgt_line = tgt_word[AW-1:OFF_W];
  assign bid      = waddr[ID_W-1:0];
endmodule

// File: rtl/bpf_pf_queue.sv
// Prefetch request FIFO; entries of a resolved branch's losing path are marked dead.
module bpf_pf_queue #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned LINE_W = 22,
  parameter int unsigned ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [LINE_W-1:0] push_line,
  input  logic              push_spec,
  input  logic [ID_W-1:0]   push_id,
  input  logic              push_path,
  input  logic              pop_en,
  input  logic              br_valid,
  input  logic [ID_W-1:0]   br_id,
  input  logic              br_taken,
  output logic              empty,
  output logic [LINE_W-1:0] head_line,
  output logic              head_spec,
  output logic [ID_W-1:0]   head_id,
  output logic              head_path,
  output logic              head_dead
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;

  logic [LINE_W-1:0] e_line [DEPTH];
  logic [ID_W-1:0]   e_id   [DEPTH];
  logic [DEPTH-1:0]  e_spec, e_path, e_dead;
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  cnt;
  logic              full, do_push, do_pop, in_hit;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push_en && !full;
  assign do_pop  = pop_en && !empty;
  assign in_hit  = br_valid && push_spec && (push_id == br_id);

  assign head_line = e_line[rd_ptr];
  assign head_spec = e_spec[rd_ptr];
  assign head_id   = e_id[rd_ptr];
  assign head_path = e_path[rd_ptr];
  assign head_dead = e_dead[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      e_spec <= '0;
      e_path <= '0;
      e_dead <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_line[i] <= '0;
        e_id[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (br_valid && e_spec[i] && (e_id[i] == br_id)) begin
          e_spec[i] <= 1'b0;
          if (e_path[i] != br_taken) e_dead[i] <= 1'b1;
        end
      end
      if (do_push) begin
        e_line[wr_ptr] <= push_line;
        e_id[wr_ptr]   <= push_id;
        e_path[wr_ptr] <= push_path;
        e_spec[wr_ptr] <= push_spec && !in_hit;
        e_dead[wr_ptr] <= in_hit && (push_path != br_taken);
        wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      end
      if (do_pop) begin
        rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/bpf_line_store.sv
// Direct-mapped line store with per-line speculation tag.
module bpf_line_store
  import bpf_pkg::*;
#(
  parameter int unsigned LINE_W = 22,
  parameter int unsigned NLINES = 16,
  parameter int unsigned WPL    = 4,
  parameter int unsigned ID_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LINE_W-1:0]          a_line,
  input  logic [$clog2(WPL)-1:0]     a_off,
  output logic                       a_hit,
  output logic [WORD_W-1:0]          a_data,
  input  logic [LINE_W-1:0]          b_line,
  output logic                       b_hit,
  input  logic                       wr_en,
  input  logic [LINE_W-1:0]          wr_line,
  input  logic [$clog2(WPL)-1:0]     wr_off,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic                       inst_en,
  input  logic                       inst_spec,
  input  logic [ID_W-1:0]            inst_id,
  input  logic                       inst_path,
  input  logic                       br_valid,
  input  logic [ID_W-1:0]            br_id,
  input  logic                       br_taken
);
  localparam int unsigned IDX_W = $clog2(NLINES);
  localparam int unsigned TAG_W = LINE_W - IDX_W;

  logic [WORD_W-1:0] dat [NLINES][WPL];
  logic [TAG_W-1:0]  tag [NLINES];
  logic [ID_W-1:0]   sid [NLINES];
  logic [NLINES-1:0] vld, spc, pth;

  logic [IDX_W-1:0] a_idx, b_idx, w_idx;
  assign a_idx = a_line[IDX_W-1:0];
  assign b_idx = b_line[IDX_W-1:0];
  assign w_idx = wr_line[IDX_W-1:0];

  assign a_hit  = vld[a_idx] && (tag[a_idx] == a_line[LINE_W-1:IDX_W]);
  assign b_hit  = vld[b_idx] && (tag[b_idx] == b_line[LINE_W-1:IDX_W]);
  assign a_data = dat[a_idx][a_off];

  always_ff @(posedge clk) begin
    if (wr_en) dat[w_idx][wr_off] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      spc <= '0;
      pth <= '0;
      for (int i = 0; i < NLINES; i++) begin
        tag[i] <= '0;
        sid[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NLINES; i++) begin
        if (br_valid && vld[i] && spc[i] && (sid[i] == br_id)) begin
          if (pth[i] == br_taken) spc[i] <= 1'b0;
          else                    vld[i] <= 1'b0;
        end
      end
      if (wr_en) vld[w_idx] <= 1'b0;
      if (inst_en) begin
        vld[w_idx] <= 1'b1;
        tag[w_idx] <= wr_line[LINE_W-1:IDX_W];
        spc[w_idx] <= inst_spec;
        sid[w_idx] <= inst_id;
        pth[w_idx] <= inst_path;
      end
    end
  end
endmodule

// File: rtl/bpf_ctrl.sv
// Fetch front end: demand service, sequential and branch-target prefetch.
module bpf_ctrl
  import bpf_pkg::*;
#(
  parameter int unsigned AW         = 24,
  parameter int unsigned WPL        = 4,
  parameter int unsigned NLINES     = 16,
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned QDEPTH     = 4,
  parameter int unsigned ID_W       = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_req_valid,
  output logic            cpu_req_ready,
  input  logic [AW-1:0]   cpu_req_addr,
  output logic            cpu_rsp_valid,
  input  logic            cpu_rsp_ready,
  output logic [31:0]     cpu_rsp_data,
  output logic            cpu_rsp_hit,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [AW-1:0]   mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [31:0]     mem_rsp_data,
  input  logic            br_valid,
  input  logic [ID_W-1:0] br_id,
  input  logic            br_taken
);
  localparam int unsigned OFF_W    = $clog2(WPL);
  localparam int unsigned LINE_W   = AW - OFF_W;
  localparam int unsigned PG_LINES = PAGE_BYTES / (4 * WPL);
  localparam int unsigned PG_BITS  = $clog2(PG_LINES);

  ctrl_state_e       state;
  logic [LINE_W-1:0] cur_line;
  logic [OFF_W-1:0]  req_off, beat;
  logic [31:0]       rsp_data_q;
  logic              rsp_hit_q, seq_pend, cond_seen;
  logic [ID_W-1:0]   cond_id;
  logic              pf_spec, pf_path, pf_dead;
  logic [ID_W-1:0]   pf_id;

  // line store
  logic              ls_a_hit, ls_b_hit, ls_wr_en, ls_inst_en, ls_inst_spec;
  logic [31:0]       ls_a_data;
  // queue
  logic              q_push, q_pop, q_empty, q_hspec, q_hpath, q_hdead;
  logic [LINE_W-1:0] q_pline, q_hline;
  logic              q_pspec, q_ppath;
  logic [ID_W-1:0]   q_pid, q_hid;
  // scanner
  logic              sc_jump, sc_cond;
  logic [LINE_W-1:0] sc_tgt;
  logic [ID_W-1:0]   sc_id;

  logic last_beat, fill_beat, page_end;
  logic pf_br_hit, pf_dead_eff, pf_spec_eff;
  logic hd_br_hit, hd_dead_eff, hd_spec_eff;
  logic scan_push, seq_push;

  assign last_beat = (beat == OFF_W'(WPL - 1));
  assign fill_beat = mem_rsp_valid && (state == ST_DFILL || state == ST_PFILL);
  assign page_end  = &cur_line[PG_BITS-1:0];

  // same-cycle resolve applied to the in-flight prefetch and the queue head
  assign pf_br_hit   = br_valid && pf_spec && (pf_id == br_id);
  assign pf_dead_eff = pf_dead || (pf_br_hit && (pf_path != br_taken));
  assign pf_spec_eff = pf_spec && !pf_br_hit;
  assign hd_br_hit   = br_valid && q_hspec && (q_hid == br_id);
  assign hd_dead_eff = q_hdead || (hd_br_hit && (q_hpath != br_taken));
  assign hd_spec_eff = q_hspec && !hd_br_hit;

  assign cpu_req_ready = (state == ST_IDLE);
  assign cpu_rsp_valid = (state == ST_RESP);
  assign cpu_rsp_data  = rsp_data_q;
  assign cpu_rsp_hit   = rsp_hit_q;
  assign mem_req_valid = (state == ST_DREQ) || (state == ST_PREQ);
  assign mem_req_addr  = {cur_line, {OFF_W{1'b0}}};

  assign ls_wr_en     = fill_beat;
  assign ls_inst_en   = fill_beat && last_beat && (state == ST_DFILL || !pf_dead_eff);
  assign ls_inst_spec = (state == ST_PFILL) && pf_spec_eff;

  assign scan_push = (state == ST_DFILL) && mem_rsp_valid && (sc_jump || sc_cond);
  assign seq_push  = (state == ST_RESP) && seq_pend && (!page_end || cond_seen);
  assign q_push    = scan_push || seq_push;
  assign q_pline   = scan_push ? sc_tgt : cur_line + LINE_W'(1);
  assign q_pspec   = scan_push ? sc_cond : cond_seen;
  assign q_pid     = scan_push ? sc_id : cond_id;
  assign q_ppath   = scan_push;
  assign q_pop     = (state == ST_IDLE) && !cpu_req_valid && !q_empty;

  bpf_line_store #(.LINE_W(LINE_W), .NLINES(NLINES), .WPL(WPL), .ID_W(ID_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .a_line(cpu_req_addr[AW-1:OFF_W]), .a_off(cpu_req_addr[OFF_W-1:0]),
    .a_hit(ls_a_hit), .a_data(ls_a_data),
    .b_line(q_hline), .b_hit(ls_b_hit),
    .wr_en(ls_wr_en), .wr_line(cur_line), .wr_off(beat), .wr_data(mem_rsp_data),
    .inst_en(ls_inst_en), .inst_spec(ls_inst_spec), .inst_id(pf_id), .inst_path(pf_path),
    .br_valid(br_valid), .br_id(br_id), .br_taken(br_taken)
  );

  bpf_pf_queue #(.DEPTH(QDEPTH), .LINE_W(LINE_W), .ID_W(ID_W)) queue_i (
    .clk(clk), .rst_n(rst_n),
    .push_en(q_push), .push_line(q_pline), .push_spec(q_pspec), .push_id(q_pid),
    .push_path(q_ppath), .pop_en(q_pop),
    .br_valid(br_valid), .br_id(br_id), .br_taken(br_taken),
    .empty(q_empty), .head_line(q_hline), .head_spec(q_hspec), .head_id(q_hid),
    .head_path(q_hpath), .head_dead(q_hdead)
  );

  bpf_scan #(.AW(AW), .OFF_W(OFF_W), .ID_W(ID_W)) scan_i (
    .word(mem_rsp_data), .waddr({cur_line, beat}),
    .is_jump(sc_jump), .is_cond(sc_cond), .tgt_line(sc_tgt), .bid(sc_id)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_line   <= '0;
      req_off    <= '0;
      beat       <= '0;
      rsp_data_q <= '0;
      rsp_hit_q  <= 1'b0;
      seq_pend   <= 1'b0;
      cond_seen  <= 1'b0;
      cond_id    <= '0;
      pf_spec    <= 1'b0;
      pf_path    <= 1'b0;
      pf_dead    <= 1'b0;
      pf_id      <= '0;
    end else begin
      pf_spec <= pf_spec_eff;
      pf_dead <= pf_dead_eff;
      case (state)
        ST_IDLE: begin
          if (cpu_req_valid) begin
            if (ls_a_hit) begin
              rsp_data_q <= ls_a_data;
              rsp_hit_q  <= 1'b1;
              seq_pend   <= 1'b0;
              state      <= ST_RESP;
            end else begin
              cur_line  <= cpu_req_addr[AW-1:OFF_W];
              req_off   <= cpu_req_addr[OFF_W-1:0];
              cond_seen <= 1'b0;
              state     <= ST_DREQ;
            end
          end else if (!q_empty && !hd_dead_eff && !ls_b_hit) begin
            cur_line <= q_hline;
            pf_spec  <= hd_spec_eff;
            pf_id    <= q_hid;
            pf_path  <= q_hpath;
            pf_dead  <= 1'b0;
            state    <= ST_PREQ;
          end
        end
        ST_DREQ, ST_PREQ: begin
          if (mem_req_ready) begin
            beat  <= '0;
            state <= (state == ST_DREQ) ? ST_DFILL : ST_PFILL;
          end
        end
        ST_DFILL: begin
          if (mem_rsp_valid) begin
            beat <= beat + OFF_W'(1);
            if (beat == req_off) rsp_data_q <= mem_rsp_data;
            if (sc_cond) begin
              cond_seen <= 1'b1;
              cond_id   <= sc_id;
            end
            if (last_beat) begin
              rsp_hit_q <= 1'b0;
              seq_pend  <= 1'b1;
              state     <= ST_RESP;
            end
          end
        end
        ST_PFILL: begin
          if (mem_rsp_valid) begin
            beat <= beat + OFF_W'(1);
            if (last_beat) state <= ST_IDLE;
          end
        end
        ST_RESP: begin
          seq_pend <= 1'b0;
          if (cpu_rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bpf_ctrl_chk.sv
module bpf_ctrl_chk #(
  parameter int unsigned AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req_valid,
  input logic          cpu_req_ready,
  input logic          cpu_rsp_valid,
  input logic          cpu_rsp_ready,
  input logic [31:0]   cpu_rsp_data,
  input logic          cpu_rsp_hit,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          lookup_hit
);
  // R10
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && !cpu_rsp_ready |=> cpu_rsp_valid && $stable(cpu_rsp_data) && $stable(cpu_rsp_hit));

  // R10
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready |=> !cpu_req_ready);

  // R1
  hit_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready && lookup_hit |=> cpu_rsp_valid && cpu_rsp_hit);

  // R1
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready && lookup_hit |=> !mem_req_valid);

  // R2
  miss_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready && !lookup_hit |=> mem_req_valid && !cpu_rsp_valid);
endmodule

bind bpf_ctrl bpf_ctrl_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
  .cpu_rsp_data(cpu_rsp_data), .cpu_rsp_hit(cpu_rsp_hit),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .lookup_hit(ls_a_hit)
);

// File: tb/bpf_ctrl_tb_top.sv
`timescale 1ns/1ps
module bpf_ctrl_tb_top;
  localparam int unsigned AW  = 24;
  localparam int unsigned WPL = 4;
  localparam int unsigned LAT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req_valid = 1'b0;
  logic          cpu_req_ready;
  logic [AW-1:0] cpu_req_addr = '0;
  logic          cpu_rsp_valid;
  logic          cpu_rsp_ready = 1'b1;
  logic [31:0]   cpu_rsp_data;
  logic          cpu_rsp_hit;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [31:0]   mem_rsp_data = '0;
  logic          br_valid = 1'b0;
  logic [3:0]    br_id = '0;
  logic          br_taken = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit rnd_bp = 1'b0;
  logic [AW-1:0] mlog [512];
  int mlog_n = 0;

  always #4 clk = ~clk;

  bpf_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_addr(cpu_req_addr),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready),
    .cpu_rsp_data(cpu_rsp_data), .cpu_rsp_hit(cpu_rsp_hit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .br_valid(br_valid), .br_id(br_id), .br_taken(br_taken)
  );

  // backing memory contents
  function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
    case (a)
      24'h000100: return {8'h01, 24'h002008};
      24'h000101: return {8'h02, 24'h00300C};
      24'h000200: return {8'h02, 24'h004010};
      24'h000300: return {8'h01, 24'h000320};
      24'h000301: return {8'h01, 24'h000330};
      24'h000302: return {8'h01, 24'h000340};
      24'h000303: return {8'h01, 24'h000350};
      default:    return {8'h80, a};
    endcase
  endfunction

  function automatic bit logged(input logic [AW-1:0] a, input int from);
    for (int i = from; i < mlog_n; i++) if (mlog[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // memory model: fixed latency, one word per cycle, random request ready
  initial begin
    bit busy = 1'b0;
    int cnt = 0;
    int bt = 0;
    logic [AW-1:0] base = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        busy = 1'b0; mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
      end else begin
        mem_rsp_valid = 1'b0;
        if (busy) begin
          if (cnt > 0) cnt--;
          else begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem_word(base + AW'(bt));
            bt++;
            if (bt == WPL) busy = 1'b0;
          end
        end
        mem_req_ready = !busy && (($urandom % 4) != 0);
        if (mem_req_valid && mem_req_ready) begin
          if (mlog_n < 512) mlog[mlog_n] = mem_req_addr;
          mlog_n++;
          busy = 1'b1; cnt = LAT; bt = 0; base = mem_req_addr;
        end
      end
    end
  end

  task automatic do_fetch(input logic [AW-1:0] a, input bit now, output logic [31:0] d, output logic h);
    if (!now) @(negedge clk);
    cpu_req_valid = 1'b1;
    cpu_req_addr  = a;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    cpu_rsp_ready = rnd_bp ? 1'($urandom % 2) : 1'b1;
    while (!(cpu_rsp_valid && cpu_rsp_ready)) begin
      @(negedge clk);
      cpu_rsp_ready = rnd_bp ? 1'($urandom % 2) : 1'b1;
    end
    d = cpu_rsp_data;
    h = cpu_rsp_hit;
    @(negedge clk);
    cpu_rsp_ready = 1'b1;
  endtask

  task automatic resolve(input logic [3:0] id, input bit tk);
    @(negedge clk);
    br_valid = 1'b1; br_id = id; br_taken = tk;
    @(negedge clk);
    br_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic h;
    int m0;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(cpu_req_ready == 1'b1, "R11 req_ready", 32'(cpu_req_ready), 32'd1);
    chk(cpu_rsp_valid == 1'b0, "R11 rsp_valid", 32'(cpu_rsp_valid), 32'd0);
    chk(mem_req_valid == 1'b0, "R11 mem_req_valid", 32'(mem_req_valid), 32'd0);

    // R2 miss
    m0 = mlog_n;
    do_fetch(24'h010005, 1'b0, d, h);
    chk(d == mem_word(24'h010005), "R2 miss data", d, mem_word(24'h010005));
    chk(h == 1'b0, "R2 miss flag", 32'(h), 32'd0);
    chk(mlog[m0] == 24'h010004, "R2 line address", 32'(mlog[m0]), 32'h010004);
    idle(40);
    // R3 next line prefetched, then hit
    chk(logged(24'h010008, m0), "R3 next line request", 32'(mlog_n), 32'h010008);
    m0 = mlog_n;
    do_fetch(24'h010009, 1'b0, d, h);
    chk(h == 1'b1, "R1 hit flag", 32'(h), 32'd1);
    chk(d == mem_word(24'h010009), "R1 hit data", d, mem_word(24'h010009));
    chk(mlog_n == m0, "R1 no memory access", 32'(mlog_n), 32'(m0));

    // R4 page end: line 0x40FF is last of its page
    m0 = mlog_n;
    do_fetch(24'h0103FD, 1'b0, d, h);
    idle(40);
    chk(!logged(24'h010400, m0), "R4 no cross-page prefetch", 32'(mlog_n - m0), 32'd1);

    // R5/R6 jump and conditional in the line at 0x100
    m0 = mlog_n;
    do_fetch(24'h000100, 1'b0, d, h);
    chk(d == {8'h01, 24'h002008}, "R5 jump word data", d, {8'h01, 24'h002008});
    idle(80);
    chk(logged(24'h002008, m0), "R5 jump target request", 32'(mlog_n), 32'h002008);
    chk(logged(24'h00300C, m0), "R6 taken path request", 32'(mlog_n), 32'h00300C);
    chk(logged(24'h000104, m0), "R6 fall-through request", 32'(mlog_n), 32'h000104);
    do_fetch(24'h002009, 1'b0, d, h);
    chk(h == 1'b1, "R5 jump target hit", 32'(h), 32'd1);
    // branch at 0x101 has ID 1; resolve taken
    resolve(4'd1, 1'b1);
    do_fetch(24'h00300D, 1'b0, d, h);
    chk(h == 1'b1, "R7 winning path kept", 32'(h), 32'd1);
    chk(d == mem_word(24'h00300D), "R7 winning path data", d, mem_word(24'h00300D));
    do_fetch(24'h000104, 1'b0, d, h);
    chk(h == 1'b0, "R7 losing path dropped", 32'(h), 32'd0);
    idle(60);

    // R8 demand priority: back-to-back request after a fill that queued work
    do_fetch(24'h000200, 1'b0, d, h);
    m0 = mlog_n;
    do_fetch(24'h005014, 1'b1, d, h);
    chk(mlog[m0] == 24'h005014, "R8 demand first", 32'(mlog[m0]), 32'h005014);
    chk(d == mem_word(24'h005014), "R8 demand data", d, mem_word(24'h005014));
    idle(120);
    // branch at 0x200 has ID 0; resolve not taken
    resolve(4'd0, 1'b0);
    do_fetch(24'h000206, 1'b0, d, h);
    chk(h == 1'b1, "R7 fall-through kept", 32'(h), 32'd1);
    do_fetch(24'h004010, 1'b0, d, h);
    chk(h == 1'b0, "R7 not-taken target dropped", 32'(h), 32'd0);
    idle(80);

    // R9 four jump targets fill the queue; the sequential entry is dropped
    m0 = mlog_n;
    do_fetch(24'h000300, 1'b0, d, h);
    idle(150);
    chk(logged(24'h000320, m0) && logged(24'h000330, m0) &&
        logged(24'h000340, m0) && logged(24'h000350, m0),
        "R9 queued targets fetched", 32'(mlog_n - m0), 32'd5);
    chk(!logged(24'h000304, m0), "R9 overflow dropped", 32'(mlog_n - m0), 32'd5);

    // R10 random traffic with response back-pressure
    rnd_bp = 1'b1;
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      a = 24'h010000 + AW'($urandom % 256);
      do_fetch(a, 1'b0, d, h);
      chk(d == mem_word(a), "R10 random data", d, mem_word(a));
      if (($urandom % 3) == 0) idle(int'($urandom % 20));
    end
    rnd_bp = 1'b0;
    finish_run();
  end
endmodule